// File: doc/BRIEF.md
# PHY Management Register File

This block stands in for an Ethernet PHY as seen from a management bus. It holds thirty-two 16-bit registers addressed by a 5-bit register number. A read strobe returns one register's value on a registered data output, together with a one-cycle valid pulse. A write strobe stores the write data in the selected register.

Most registers are plain storage. Three are computed when read. The basic status register (number 1) reports a fixed ability set while the link is up. The link-partner ability register (number 5) echoes the locally written advertisement register (number 4), so the emulated partner always agrees with the best advertised mode. The vendor diagnostic register (number 18) reports the resolved speed and duplex. A `link_up` input controls whether a link appears present. A combinational duplex output lets the MAC side compare its own duplex setting with the PHY's.

The advertisement register uses this bit layout: bit 5 is 10 Mb/s half duplex, bit 6 is 10 Mb/s full duplex, bit 7 is 100 Mb/s half duplex and bit 8 is 100 Mb/s full duplex.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After reset, register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400 and register 4 reads 0x01E1. `rd_valid` is low and `rd_data` is 0.
- R2: A read strobe sampled at a clock edge places the value on `rd_data` and raises `rd_valid` after that same edge. `rd_valid` is high for exactly one cycle per strobe.
- R3: While `link_up` is high, a read of register 1 returns 0x782C. This value has bits 14, 13, 12, 11, 5, 3 and 2 set.
- R4: While `link_up` is low, a read of register 1 returns 0x0000.
- R5: A read of register 5 returns 0x4000 OR (register 4 AND 0x01E0) OR 0x0001, whatever the link state.
- R6: While `link_up` is high, a read of register 18 returns bit 10 = register 4 bit 7 OR bit 8, and bit 11 = register 4 bit 6 OR bit 8. All other bits are 0.
- R7: While `link_up` is low, a read of register 18 returns 0x0000.
- R8: Any register other than 1, 5 and 18 reads back the last value written to it. Writes to 1, 5 and 18 are accepted but have no effect on what those registers read.
- R9: `duplex_full` equals bit 11 of the current register 18 value, computed combinationally. It therefore reflects a write to register 4 from the cycle after that write.
- R10: When a read and a write to the same register happen in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| reg_num | input | 5 | Register number |
| wr_data | input | 16 | Write data |
| link_up | input | 1 | High when the link appears present |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` |
| duplex_full | output | 1 | Resolved full-duplex indication |

## Verification
The bound checker verifies the read handshake timing on every cycle: each strobe gives exactly one valid pulse on the next cycle. It also checks, on every cycle, that status and diagnostic reads return zero while the link is down, that the fixed bits of the partner register are always present, and that the duplex output stays low without a link. Exact computed values for each advertisement pattern, plain storage readback, the immunity of computed registers to writes and the read-before-write ordering need known stimulus. The bench's scoreboard shows these.

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile #(
  parameter int          AW       = 5,
  parameter int          DW       = 16,
  parameter logic [15:0] RST_CTRL = 16'h3100,
  parameter logic [15:0] RST_ID1  = 16'h0300,
  parameter logic [15:0] RST_ID2  = 16'hE400,
  parameter logic [15:0] RST_ADV  = 16'h01E1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] reg_num,
  input  logic [DW-1:0] wr_data,
  input  logic          link_up,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          duplex_full
);
  localparam int NREG = 1 << AW;
  localparam logic [AW-1:0] N_STAT = AW'(1);
  localparam logic [AW-1:0] N_ADV  = AW'(4);
  localparam logic [AW-1:0] N_LPA  = AW'(5);
  localparam logic [AW-1:0] N_DIAG = AW'(18);
  localparam logic [DW-1:0] STAT_UP = DW'(16'h782C);

  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] adv, diag, lpa, rd_next;
  logic          spd100, fdx;

  assign adv    = regs[N_ADV];
  assign spd100 = adv[7] | adv[8];
  assign fdx    = adv[6] | adv[8];
  assign diag   = link_up ? DW'({fdx, spd100, 10'b0}) : '0;
  assign lpa    = DW'(16'h4000) | (adv & DW'(16'h01E0)) | DW'(1);
  assign duplex_full = diag[11];

  always_comb begin
    case (reg_num)
      N_STAT:  rd_next = link_up ? STAT_UP : '0;
      N_LPA:   rd_next = lpa;
      N_DIAG:  rd_next = diag;
      default: rd_next = regs[reg_num];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      regs[0] <= DW'(RST_CTRL);
      regs[2] <= DW'(RST_ID1);
      regs[3] <= DW'(RST_ID2);
      regs[N_ADV] <= DW'(RST_ADV);
    end else if (wr_en) begin
      regs[reg_num] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/phy_mgmt_regfile_chk.sv
module phy_mgmt_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic [4:0]  reg_num,
  input logic        link_up,
  input logic [15:0] rd_data,
  input logic        rd_valid,
  input logic        duplex_full
);
  p_valid_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  p_status_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_num == 5'd1 && !link_up) |=> (rd_data == 16'h0000));
  p_partner_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_num == 5'd5) |=> (rd_data[14] && rd_data[0] && !rd_data[15]));
  p_diag_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_num == 5'd18 && !link_up) |=> (rd_data == 16'h0000));
  p_duplex_needs_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |-> !duplex_full);
endmodule

bind phy_mgmt_regfile phy_mgmt_regfile_chk u_chk (.*);

// File: tb/phy_mgmt_regfile_tb.sv
module phy_mgmt_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0, link_up = 1'b1;
  logic [4:0]  reg_num = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        rd_valid, duplex_full;

  int n_chk = 0, n_bad = 0, n_rd = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  phy_mgmt_regfile u_dut (.*);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R2 unexpected valid", 16'h1, 16'h0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  task automatic wr(input logic [4:0] n, input logic [15:0] d);
    reg_num = n; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] n, input logic [15:0] e, input string t);
    reg_num = n; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t); n_rd++;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 valid after reset", {15'b0, rd_valid}, 16'h0);
    check("R1 data after reset", rd_data, 16'h0);
    rd(5'd0, 16'h3100, "R1 reg0");
    rd(5'd2, 16'h0300, "R1 reg2");
    rd(5'd3, 16'hE400, "R1 reg3");
    rd(5'd4, 16'h01E1, "R1 reg4");
    @(negedge clk);
    check("R2 valid single pulse", {15'b0, rd_valid}, 16'h0);
    rd(5'd1, 16'h782C, "R3 status link up");
    rd(5'd5, 16'h41E1, "R5 partner default");
    rd(5'd18, 16'h0C00, "R6 diag default");
    check("R9 duplex default", {15'b0, duplex_full}, 16'h1);

    wr(5'd4, 16'h0021);
    check("R9 duplex 10half", {15'b0, duplex_full}, 16'h0);
    rd(5'd5, 16'h4021, "R5 partner 10half");
    rd(5'd18, 16'h0000, "R6 diag 10half");
    wr(5'd4, 16'h0041);
    check("R9 duplex 10full", {15'b0, duplex_full}, 16'h1);
    rd(5'd18, 16'h0800, "R6 diag 10full");
    wr(5'd4, 16'h0081);
    check("R9 duplex 100half", {15'b0, duplex_full}, 16'h0);
    rd(5'd18, 16'h0400, "R6 diag 100half");
    rd(5'd5, 16'h4081, "R5 partner 100half");
    wr(5'd4, 16'h0101);
    rd(5'd18, 16'h0C00, "R6 diag 100full");

    wr(5'd7, 16'hBEEF);
    wr(5'd31, 16'h1234);
    rd(5'd7, 16'hBEEF, "R8 reg7 readback");
    rd(5'd31, 16'h1234, "R8 reg31 readback");
    wr(5'd1, 16'hFFFF);
    wr(5'd5, 16'h0000);
    wr(5'd18, 16'h5555);
    rd(5'd1, 16'h782C, "R8 status immune");
    rd(5'd5, 16'h4101, "R8 partner immune");
    rd(5'd18, 16'h0C00, "R8 diag immune");

    wr(5'd9, 16'h1111);
    reg_num = 5'd9; wr_data = 16'h2222; wr_en = 1'b1; rd_en = 1'b1;
    exp_q.push_back(16'h1111); tag_q.push_back("R10 read before write"); n_rd++;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    rd(5'd9, 16'h2222, "R10 write landed");

    link_up = 1'b0;
    #1;
    check("R9 duplex link down", {15'b0, duplex_full}, 16'h0);
    rd(5'd1, 16'h0000, "R4 status link down");
    rd(5'd18, 16'h0000, "R7 diag link down");
    rd(5'd5, 16'h4101, "R5 partner link down");
    link_up = 1'b1;
    rd(5'd1, 16'h782C, "R3 status link restored");

    repeat (3) @(negedge clk);
    check("R2 all reads answered", 16'(exp_q.size()), 16'h0);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule